// File: doc/BRIEF.md
# Avalanche Cell-Chain Pink Noise Generator

This block produces a digital noise sequence whose spectrum falls roughly as 1/f. It holds a row of `N_CELLS` one-bit cells, each either calm (0) or charged (1). A single excitation token is dropped into cell 0 on a fixed period. A calm cell absorbs the token and becomes charged. A charged cell discharges and passes the token to its left or right neighbour, chosen by a pseudo-random bit. The token keeps moving until it is absorbed or falls off either end of the row.

After every such avalanche settles, the block reports how many cells are charged, together with a one-cycle valid strobe. A downstream filter or DAC treats the counts as noise samples. Changing the cell count moves the band over which the spectrum follows 1/f. The seed input makes every run repeatable.

Top module: `pink_ca_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all cells clear to 0, no token is in flight, the period counter returns to 0, and `sample` and `sample_vld` read 0 after that edge.
- R2: With `en` held high and no avalanche running, a token enters cell 0 at the clock edge that completes `PERIOD` enabled cycles. After release from reset into an empty row, the first `sample_vld` is therefore high in the cycle after edge `PERIOD+2`, carrying a count of 1.
- R3: A token arriving at a calm cell sets that cell to 1, and the avalanche ends at that step.
- R4: A token arriving at a charged cell clears that cell and moves to an adjacent cell. The token takes exactly one step per clock cycle, and each step changes exactly one cell. Cells never change while no token is in flight.
- R5: The direction of each step is bit 0 of a 16-bit shift register: 0 means toward cell index-1, 1 means toward index+1. The register shifts left every cycle and inserts bit15^bit13^bit12^bit10 at bit 0. It loads `seed` during reset, or 16'hACE1 when `seed` is zero.
- R6: A token that moves below cell 0 or above cell `N_CELLS-1` is discarded, and the avalanche ends at that step.
- R7: If the period completes while an avalanche is still running, the injection is held. The token enters cell 0 in the first cycle after the row is settled, and the period count then restarts from 0.
- R8: When an avalanche takes its final step at edge k, `sample_vld` is high for exactly the one cycle after edge k+1. In that cycle, `sample` equals the number of cells at 1 after the final step.
- R9: While `en` is low, the period counter holds and no token is injected. An avalanche that is already running still completes and still reports its sample.
- R10: `sample` never exceeds `N_CELLS`. It is formed by a chain of adders only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Lets the injection period advance |
| seed | input | 16 | Value loaded into the direction register during reset |
| sample | output | $clog2(N_CELLS+1) | Count of charged cells after the last settled avalanche |
| sample_vld | output | 1 | One-cycle strobe marking a new sample |

## Verification
The assertions assume reset is asserted from the first clock edge, so the row, the token and the direction register start from known values. They also assume the parameters satisfy `N_CELLS >= 2` and `PERIOD >= 2`. The bench holds `rst` high at time zero. It uses the default row length with a short period, so held injections occur often. It changes `en` and `seed` only on falling edges, including a zero seed and a reset issued in the middle of an avalanche.

// File: rtl/sca_pkg.sv
package sca_pkg;

    localparam int unsigned RNG_W = 16;
    localparam logic [RNG_W-1:0] RNG_FALLBACK = 16'hACE1;

    localparam logic STEP_DOWN = 1'b0;
    localparam logic STEP_UP   = 1'b1;

    typedef enum logic {
        TOK_IDLE = 1'b0,
        TOK_WALK = 1'b1
    } tok_state_e;

    function automatic logic [RNG_W-1:0] rng_advance(input logic [RNG_W-1:0] s);
        return {s[RNG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [RNG_W-1:0] rng_start(input logic [RNG_W-1:0] s);
        return (s == '0) ? RNG_FALLBACK : s;
    endfunction

endpackage

// File: rtl/sca_dir_rng.sv
module sca_dir_rng
    import sca_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [RNG_W-1:0] seed,
    output logic [RNG_W-1:0] state,
    output logic             dir
);

    logic [RNG_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= rng_start(seed);
        end else begin
            state_q <= rng_advance(state_q);
        end
    end

    assign state = state_q;
    assign dir   = state_q[0];

endmodule

// File: rtl/sca_period_timer.sv
module sca_period_timer #(
    parameter int unsigned PERIOD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic idle,
    output logic inject
);

    localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             expired;

    assign expired = (cnt_q == LAST);
    assign inject  = en && expired && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            if (expired) begin
                if (idle) begin
                    cnt_q <= '0;
                end
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/sca_token_walker.sv
module sca_token_walker
    import sca_pkg::*;
#(
    parameter int unsigned N_CELLS = 15
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       inject,
    input  logic                       dir,
    output logic [N_CELLS-1:0]         cells,
    output logic [$clog2(N_CELLS)-1:0] pos,
    output logic                       walking,
    output logic                       settled
);

    localparam int unsigned POS_W = $clog2(N_CELLS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(N_CELLS - 1);

    logic [N_CELLS-1:0] cells_q;
    logic [POS_W-1:0]   pos_q;
    tok_state_e         st_q;
    logic               settled_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cells_q   <= '0;
            pos_q     <= '0;
            st_q      <= TOK_IDLE;
            settled_q <= 1'b0;
        end else begin
            settled_q <= 1'b0;
            if (st_q == TOK_WALK) begin
                if (!cells_q[pos_q]) begin
                    cells_q[pos_q] <= 1'b1;
                    st_q           <= TOK_IDLE;
                    settled_q      <= 1'b1;
                end else begin
                    cells_q[pos_q] <= 1'b0;
                    if (dir == STEP_UP) begin
                        if (pos_q == POS_LAST) begin
                            st_q      <= TOK_IDLE;
                            settled_q <= 1'b1;
                        end else begin
                            pos_q <= pos_q + POS_W'(1);
                        end
                    end else begin
                        if (pos_q == '0) begin
                            st_q      <= TOK_IDLE;
                            settled_q <= 1'b1;
                        end else begin
                            pos_q <= pos_q - POS_W'(1);
                        end
                    end
                end
            end else if (inject) begin
                st_q  <= TOK_WALK;
                pos_q <= '0;
            end
        end
    end

    assign cells   = cells_q;
    assign pos     = pos_q;
    assign walking = (st_q == TOK_WALK);
    assign settled = settled_q;

endmodule

// File: rtl/sca_popcount.sv
module sca_popcount #(
    parameter int unsigned N_BITS = 15
) (
    input  logic [N_BITS-1:0]           bits,
    output logic [$clog2(N_BITS+1)-1:0] total
);

    localparam int unsigned CW = $clog2(N_BITS + 1);

    logic [CW-1:0] partial [0:N_BITS];

    assign partial[0] = '0;

    for (genvar g = 0; g < N_BITS; g++) begin : g_add
        assign partial[g+1] = partial[g] + CW'(bits[g]);
    end

    assign total = partial[N_BITS];

endmodule

// File: rtl/pink_ca_gen.sv
module pink_ca_gen
    import sca_pkg::*;
#(
    parameter int unsigned N_CELLS = 15,
    parameter int unsigned PERIOD  = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic [15:0]                  seed,
    output logic [$clog2(N_CELLS+1)-1:0] sample,
    output logic                         sample_vld
);

    localparam int unsigned POS_W = $clog2(N_CELLS);
    localparam int unsigned CW    = $clog2(N_CELLS + 1);

    logic [RNG_W-1:0]   rng_state;
    logic               step_dir;
    logic               inject;
    logic [N_CELLS-1:0] cells;
    logic [POS_W-1:0]   tok_pos;
    logic               walking;
    logic               settled;
    logic [CW-1:0]      live_count;
    logic [CW-1:0]      sample_q;
    logic               vld_q;

    sca_dir_rng u_rng (
        .clk   (clk),
        .rst   (rst),
        .seed  (seed),
        .state (rng_state),
        .dir   (step_dir)
    );

    sca_period_timer #(.PERIOD(PERIOD)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .idle   (!walking),
        .inject (inject)
    );

    sca_token_walker #(.N_CELLS(N_CELLS)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .inject  (inject),
        .dir     (step_dir),
        .cells   (cells),
        .pos     (tok_pos),
        .walking (walking),
        .settled (settled)
    );

    sca_popcount #(.N_BITS(N_CELLS)) u_count (
        .bits  (cells),
        .total (live_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= settled;
            if (settled) begin
                sample_q <= live_count;
            end
        end
    end

    assign sample     = sample_q;
    assign sample_vld = vld_q;

endmodule

// File: rtl/sca_noise_checker.sv
module sca_noise_checker #(
    parameter int unsigned N_CELLS = 15
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         walking,
    input logic [$clog2(N_CELLS)-1:0]   pos,
    input logic [N_CELLS-1:0]           cells,
    input logic                         inject,
    input logic [$clog2(N_CELLS+1)-1:0] sample,
    input logic                         sample_vld,
    input logic [15:0]                  rng
);

    localparam int unsigned POS_W = $clog2(N_CELLS);

    AST_POS_IN_CHAIN: assert property (@(posedge clk) disable iff (rst)
        walking |-> (int'(pos) < N_CELLS)); // R4

    AST_ONE_CELL_PER_STEP: assert property (@(posedge clk) disable iff (rst)
        walking |=> ($countones(cells ^ $past(cells)) == 1)); // R4

    AST_IDLE_CELLS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!walking && !inject) |=> $stable(cells)); // R4

    AST_STEP_ADJACENT: assert property (@(posedge clk) disable iff (rst)
        walking |=> (!walking || pos == $past(pos) + POS_W'(1)
                                || pos == $past(pos) - POS_W'(1))); // R4

    AST_INJECT_AT_HEAD: assert property (@(posedge clk) disable iff (rst)
        inject |=> (walking && pos == '0)); // R2

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_vld |=> !sample_vld); // R8

    AST_SAMPLE_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(sample) <= N_CELLS); // R10

    AST_RNG_NONZERO: assert property (@(posedge clk) disable iff (rst)
        rng != '0); // R5

endmodule

bind pink_ca_gen sca_noise_checker #(.N_CELLS(N_CELLS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .walking    (walking),
    .pos        (tok_pos),
    .cells      (cells),
    .inject     (inject),
    .sample     (sample),
    .sample_vld (sample_vld),
    .rng        (rng_state)
);

// File: tb/pink_ca_gen_bench.sv
module pink_ca_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 15;
    localparam int P  = 5;
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [15:0]   seed = 16'h1D2C;
    logic [CW-1:0] sample;
    logic          sample_vld;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int first_vld_cyc = -1;
    int vld_seen = 0;

    // bench model state
    logic [N-1:0] m_cells;
    int           m_pos;
    logic         m_walk;
    int           m_cnt;
    logic [15:0]  m_rng;
    logic         m_done;
    logic         m_vld;
    int           m_sample;
    int           m_steps;
    logic         m_lost;
    logic         m_deferred;
    int           r_steps;
    logic         r_lost;
    logic         r_deferred;

    pink_ca_gen #(.N_CELLS(N), .PERIOD(P)) u_pink_ca_gen (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .seed       (seed),
        .sample     (sample),
        .sample_vld (sample_vld)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [15:0] rng_next(input logic [15:0] s);
        logic fb;
        fb = s[15] ^ s[13] ^ s[12] ^ s[10];
        return {s[14:0], fb};
    endfunction

    task automatic model_step();
        logic [N-1:0] nc;
        int           np;
        logic         nw;
        logic         nd;
        logic         inj;
        if (rst) begin
            m_cells = '0; m_pos = 0; m_walk = 1'b0; m_cnt = 0;
            m_rng = (seed == 16'h0) ? 16'hACE1 : seed;
            m_done = 1'b0; m_vld = 1'b0; m_sample = 0;
            m_steps = 0; m_lost = 1'b0; m_deferred = 1'b0;
        end else begin
            nc = m_cells; np = m_pos; nw = m_walk; nd = 1'b0;
            m_vld = m_done;
            if (m_done) begin
                m_sample = $countones(m_cells);
                r_steps = m_steps; r_lost = m_lost; r_deferred = m_deferred;
            end
            inj = en && (m_cnt == P - 1) && !m_walk;
            if (en && (m_cnt == P - 1) && m_walk) m_deferred = 1'b1;
            if (en) begin
                if (m_cnt == P - 1) begin
                    if (inj) m_cnt = 0;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (m_walk) begin
                m_steps++;
                if (!m_cells[m_pos]) begin
                    nc[m_pos] = 1'b1; nw = 1'b0; nd = 1'b1;
                end else begin
                    nc[m_pos] = 1'b0;
                    if (m_rng[0]) begin
                        if (m_pos == N - 1) begin nw = 1'b0; nd = 1'b1; m_lost = 1'b1; end
                        else np = m_pos + 1;
                    end else begin
                        if (m_pos == 0) begin nw = 1'b0; nd = 1'b1; m_lost = 1'b1; end
                        else np = m_pos - 1;
                    end
                end
            end else if (inj) begin
                nw = 1'b1; np = 0;
                m_steps = 0; m_lost = 1'b0; m_deferred = 1'b0;
            end
            m_cells = nc; m_pos = np; m_walk = nw; m_done = nd;
            m_rng = rng_next(m_rng);
        end
    endtask

    task automatic compare();
        string tag;
        checks++;
        if (sample_vld !== m_vld) begin
            fails++;
            $display("FAIL R8 cycle %0d sample_vld got %0b exp %0b", cyc, sample_vld, m_vld);
        end
        if (m_vld) begin
            vld_seen++;
            tag = "R8";
            if (r_steps == 1 && !r_lost) tag = {tag, " R3"};
            if (r_steps > 1) tag = {tag, " R4 R5"};
            if (r_lost) tag = {tag, " R6"};
            if (r_deferred) tag = {tag, " R7"};
            checks++;
            if (int'(sample) !== m_sample) begin
                fails++;
                $display("FAIL %s cycle %0d sample got %0d exp %0d", tag, cyc, sample, m_sample);
            end
            checks++;
            if (int'(sample) > N) begin
                fails++;
                $display("FAIL R10 cycle %0d sample got %0d exp <= %0d", cyc, sample, N);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        cyc++;
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset(input logic [15:0] s);
        rst = 1'b1; seed = s;
        repeat (3) tick();
        checks++;
        if (sample !== '0 || sample_vld !== 1'b0) begin
            fails++;
            $display("FAIL R1 after reset sample=%0d vld=%0b exp 0 0", sample, sample_vld);
        end
        rst = 1'b0;
        cyc = 0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        en = 1'b1;
        do_reset(16'h1D2C);

        // R2: first sample after reset into an empty row
        first_vld_cyc = -1;
        for (int i = 0; i < 3000; i++) begin
            tick();
            if (first_vld_cyc < 0 && sample_vld) begin
                first_vld_cyc = cyc;
                checks++;
                if (cyc != P + 2 || sample != CW'(1)) begin
                    fails++;
                    $display("FAIL R2 first strobe cycle %0d count %0d exp cycle %0d count 1",
                             cyc, sample, P + 2);
                end
            end
        end

        // random enable pattern
        for (int i = 0; i < 3000; i++) begin
            en = ($urandom % 4) != 0;
            tick();
        end

        // R9: enable low, running walk drains then silence
        en = 1'b0;
        repeat (50) tick();
        vld_seen = 0;
        repeat (150) tick();
        checks++;
        if (vld_seen != 0) begin
            fails++;
            $display("FAIL R9 strobes with en low got %0d exp 0", vld_seen);
        end

        // R5: zero seed falls back to the fixed nonzero value
        en = 1'b1;
        do_reset(16'h0000);
        for (int i = 0; i < 2000; i++) begin
            if (i % 97 == 0) en = ($urandom % 2) != 0;
            tick();
        end

        // R1: reset in the middle of activity, new random seed
        en = 1'b1;
        do_reset(16'($urandom));
        for (int i = 0; i < 1500; i++) tick();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired at cycle %0d exp run to finish", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule